// File: doc/BRIEF.md
# Sixteen-Channel DMA Register and Interrupt Front-End

This block is the memory-mapped control face of a sixteen-channel DMA engine. A simple 32-bit register bus reads and writes per-channel setup words: a buffer pointer, a line length, a line count, a control word and a stride. Each channel also has shared bits in a pending-event register, an event mask register and a ring-mode register. Writing a channel's pointer word launches that channel. Writing ones to the halt register stops the channels named by those bits. Both actions reach the channel sequencers as one-cycle pulses.

Sequencers report completions and half-buffer crossings on a sixteen-bit event input. An event sets its channel's pending bit whether or not that channel is masked in. A single level interrupt is raised while any pending bit is also enabled. The mask and ring registers each have a clear alias, so software can drop individual bits without a read-modify-write. Ring mode for a channel needs two bits set together: its low bit and its partner sixteen places higher. Clearing either one pauses looping, and setting both again resumes it.

Top module: `dma_regfront`

## Requirements
- R1: After reset, every register reads zero, `irq` is low, and `start_pulse`, `stop_pulse` and `ring_en` are all zero.
- R2: Channel n's window is at byte offset n*0x10. The pointer is at +0x0, the line length at +0x4 and the line count at +0x8, each read back as written. The stride for channel n is at 0x100 + 4*n and also reads back as written.
- R3: The control word is at +0xC in the channel window. Bits [31:4] hold what was written. Bits [3:0] always read as the channel index n.
- R4: A write to channel n's pointer word drives `start_pulse` to exactly 1<<n for the one cycle after the write and to zero afterwards. Writes to the other channel words do not pulse `start_pulse`.
- R5: Writing a value V to 0x140 drives `stop_pulse` to V[15:0] for one cycle. Reading 0x140 returns the channels that have been started and not stopped since.
- R6: A high `ch_event[n]` sets bit n of the status register at 0x144 even when the channel is masked. `irq` stays low while no set status bit is enabled.
- R7: Writing ones to 0x144 clears those status bits and leaves the other status bits as they were.
- R8: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R9: A write to 0x148 loads the enable register. A write to 0x14C clears only the enable bits written as one. `irq` is high exactly when status AND enable is nonzero.
- R10: The loop register at 0x150 loads on a write. A write to 0x15C clears the loop bits written as one. `ring_en[n]` is high only while loop bits n and n+16 are both set.
- R11: Reads of unmapped or misaligned offsets, and of the two clear aliases, return zero. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 10 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| ch_event | input | 16 | Per-channel completion or half-buffer event |
| irq | output | 1 | Level interrupt |
| start_pulse | output | 16 | One-cycle start request per channel |
| stop_pulse | output | 16 | One-cycle halt request per channel |
| ring_en | output | 16 | Ring mode active per channel |

## Verification
The interrupt path is driven in four ways: an event on a masked channel, an event followed by a mask write, a clear through the mask alias, and an event landing in the same cycle as its own clear. Together these separate a status bit that sets on its own from one gated by the mask, and show whether set or clear wins on a collision. The ring register is driven with one bit of a pair, with both bits, and through the clear alias. This shows that only a complete pair turns ring mode on. Register readback uses different channels and values with every bit set. This exposes a wrong window stride and a writable channel-index field. Launch and halt writes check that each pulse is one-hot or matches the written mask, and that it lasts a single cycle.

// File: rtl/dma_regfront.sv
module dma_regfront (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [9:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [15:0] ch_event,
  output logic        irq,
  output logic [15:0] start_pulse,
  output logic [15:0] stop_pulse,
  output logic [15:0] ring_en
);
  localparam int NCH = 16;

  logic [31:0] ptr_q    [NCH];
  logic [31:0] xlen_q   [NCH];
  logic [31:0] ylen_q   [NCH];
  logic [27:0] ctrl_q   [NCH];
  logic [31:0] stride_q [NCH];
  logic [15:0] status_q, enable_q, active_q;
  logic [31:0] loop_q;

  wire [7:0] wi      = bus_addr[9:2];
  wire       aligned = (bus_addr[1:0] == 2'b00);
  wire       wr      = bus_sel & bus_wr;
  wire [3:0] ch      = wi[5:2];
  wire       in_ch   = aligned && (wi[7:6] == 2'b00);
  wire       in_str  = aligned && (wi[7:4] == 4'h4);
  wire       hit_halt = aligned && wi == 8'h50;
  wire       hit_stat = aligned && wi == 8'h51;
  wire       hit_en   = aligned && wi == 8'h52;
  wire       hit_encl = aligned && wi == 8'h53;
  wire       hit_loop = aligned && wi == 8'h54;
  wire       hit_lpcl = aligned && wi == 8'h57;
  wire       mapped   = in_ch | in_str | hit_halt | hit_stat | hit_en |
                        hit_encl | hit_loop | hit_lpcl;

  wire [15:0] start_d = (wr && in_ch && wi[1:0] == 2'd0) ? (16'd1 << ch) : 16'd0;
  wire [15:0] stop_d  = (wr && hit_halt) ? bus_wdata[15:0] : 16'd0;
  wire [15:0] w1c     = (wr && hit_stat) ? bus_wdata[15:0] : 16'd0;

  assign irq = |(status_q & enable_q);
  assign ring_en = loop_q[15:0] & loop_q[31:16];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        ptr_q[i] <= '0; xlen_q[i] <= '0; ylen_q[i] <= '0;
        ctrl_q[i] <= '0; stride_q[i] <= '0;
      end
      status_q <= '0; enable_q <= '0; active_q <= '0; loop_q <= '0;
      start_pulse <= '0; stop_pulse <= '0;
    end else begin
      start_pulse <= start_d;
      stop_pulse  <= stop_d;
      status_q    <= (status_q & ~w1c) | ch_event;
      active_q    <= (active_q | start_d) & ~stop_d;
      if (wr) begin
        if (in_ch) begin
          case (wi[1:0])
            2'd0: ptr_q[ch]  <= bus_wdata;
            2'd1: xlen_q[ch] <= bus_wdata;
            2'd2: ylen_q[ch] <= bus_wdata;
            default: ctrl_q[ch] <= bus_wdata[31:4];
          endcase
        end
        if (in_str)   stride_q[wi[3:0]] <= bus_wdata;
        if (hit_en)   enable_q <= bus_wdata[15:0];
        if (hit_encl) enable_q <= enable_q & ~bus_wdata[15:0];
        if (hit_loop) loop_q   <= bus_wdata;
        if (hit_lpcl) loop_q   <= loop_q & ~bus_wdata;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (in_ch) begin
      case (wi[1:0])
        2'd0: bus_rdata = ptr_q[ch];
        2'd1: bus_rdata = xlen_q[ch];
        2'd2: bus_rdata = ylen_q[ch];
        default: bus_rdata = {ctrl_q[ch], ch};
      endcase
    end else if (in_str)  bus_rdata = stride_q[wi[3:0]];
    else if (hit_halt)    bus_rdata = {16'd0, active_q};
    else if (hit_stat)    bus_rdata = {16'd0, status_q};
    else if (hit_en)      bus_rdata = {16'd0, enable_q};
    else if (hit_loop)    bus_rdata = loop_q;
  end

  assert_start_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_pulse));
  assert_start_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|start_pulse) |-> $past(bus_sel && bus_wr && bus_addr[1:0] == 2'b00));
  assert_stop_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|stop_pulse) |-> $past(bus_sel && bus_wr && bus_addr == 10'h140));
  assert_event_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_q & ~$past(status_q))) |-> (|$past(ch_event)));
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_event) |=> ((status_q & $past(ch_event)) == $past(ch_event)));
  assert_unmapped_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !mapped) |=> ($stable(enable_q) && $stable(loop_q)));
endmodule

// File: tb/dma_regfront_tb.sv
module dma_regfront_tb;
  logic clk = 0, rst_n = 0, bus_sel = 0, bus_wr = 0;
  logic [9:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [15:0] ch_event = '0, start_pulse, stop_pulse, ring_en;
  logic irq;
  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  dma_regfront u_dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ch_event(ch_event), .irq(irq), .start_pulse(start_pulse),
    .stop_pulse(stop_pulse), .ring_en(ring_en));

  always @(negedge clk) if (bus_sel && !bus_wr && exp_q.size() > 0) begin
    logic [31:0] e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    total++;
    if (bus_rdata !== e) begin
      bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", t, bus_addr, bus_rdata, e);
    end
  end

  task automatic chk(string t, logic [31:0] act, logic [31:0] e);
    total++;
    if (act !== e) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", t, act, e);
    end
  endtask

  task automatic bw(logic [9:0] a, logic [31:0] d, logic [15:0] ev = 16'd0);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; ch_event = ev;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0; ch_event = '0;
  endtask

  task automatic br(logic [9:0] a, logic [31:0] e, string t);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic pulse_ev(logic [15:0] ev);
    @(posedge clk); #1; ch_event = ev;
    @(posedge clk); #1; ch_event = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 pulses/ring", {start_pulse, stop_pulse | ring_en}, 0);
    br(10'h144, 0, "R1 status");
    br(10'h148, 0, "R1 enable");
    br(10'h150, 0, "R1 loop");
    br(10'h034, 0, "R1 xlen ch3");

    // R2 readback
    bw(10'h034, 32'h0000_1234);
    bw(10'h038, 32'hFFFF_FFFF);
    bw(10'h114, 32'hA5A5_0004);
    br(10'h034, 32'h0000_1234, "R2 xlen ch3");
    br(10'h038, 32'hFFFF_FFFF, "R2 ylen ch3");
    br(10'h114, 32'hA5A5_0004, "R2 stride ch5");
    br(10'h044, 0, "R2 xlen ch4 untouched");

    // R3 control index field
    bw(10'h09C, 32'hFFFF_FFFF);
    br(10'h09C, 32'hFFFF_FFF9, "R3 ctrl ch9");
    br(10'h0FC, 32'h0000_000F, "R3 ctrl ch15");
    chk("R4 no start on ctrl write", {16'd0, start_pulse}, 0);

    // R4 start
    bw(10'h070, 32'h8000_0000);
    chk("R4 start ch7", {16'd0, start_pulse}, 32'h80);
    @(posedge clk); #1;
    chk("R4 start one cycle", {16'd0, start_pulse}, 0);
    br(10'h070, 32'h8000_0000, "R2 ptr ch7");

    // R5 stop
    bw(10'h000, 32'h1);
    br(10'h140, 32'h81, "R5 active");
    bw(10'h140, 32'h0000_0081);
    chk("R5 stop pulse", {16'd0, stop_pulse}, 32'h81);
    @(posedge clk); #1;
    chk("R5 stop one cycle", {16'd0, stop_pulse}, 0);
    br(10'h140, 0, "R5 active cleared");

    // R6 event while masked
    pulse_ev(16'h0004);
    br(10'h144, 32'h4, "R6 status set masked");
    chk("R6 irq low masked", {31'd0, irq}, 0);
    // R9 enable and clear alias
    bw(10'h148, 32'h0000_0014);
    chk("R9 irq high", {31'd0, irq}, 1);
    bw(10'h14C, 32'h0000_0004);
    br(10'h148, 32'h10, "R9 enable after alias clear");
    chk("R9 irq low after clear", {31'd0, irq}, 0);
    br(10'h14C, 0, "R11 alias read zero");
    // R7 w1c
    pulse_ev(16'h0100);
    bw(10'h144, 32'h0000_0004);
    br(10'h144, 32'h100, "R7 w1c selective");
    bw(10'h144, 32'h0000_0100);
    br(10'h144, 0, "R7 w1c all");
    // R8 set wins
    bw(10'h144, 32'h0000_0020, 16'h0020);
    br(10'h144, 32'h20, "R8 set wins");
    bw(10'h148, 32'h0000_0020);
    chk("R8 irq", {31'd0, irq}, 1);
    bw(10'h144, 32'h0000_0020);
    chk("R9 irq drops with status", {31'd0, irq}, 0);

    // R10 loop
    bw(10'h150, 32'h0000_0002);
    chk("R10 half pair", {16'd0, ring_en}, 0);
    bw(10'h150, 32'h0003_0003);
    chk("R10 both pairs", {16'd0, ring_en}, 32'h3);
    bw(10'h15C, 32'h0001_0000);
    chk("R10 paused ch0", {16'd0, ring_en}, 32'h2);
    br(10'h150, 32'h0002_0003, "R10 loop after clear");
    br(10'h15C, 0, "R11 loop alias read");
    bw(10'h150, 32'h0003_0003);
    chk("R10 resume", {16'd0, ring_en}, 32'h3);

    // R11 unmapped
    bw(10'h154, 32'hFFFF_FFFF);
    bw(10'h200, 32'hFFFF_FFFF);
    bw(10'h14A, 32'hFFFF_FFFF);
    br(10'h200, 0, "R11 unmapped read");
    br(10'h036, 0, "R11 misaligned read");
    br(10'h148, 32'h20, "R11 enable unchanged");
    br(10'h150, 32'h0003_0003, "R11 loop unchanged");

    repeat (2) @(posedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule